// File: doc/BRIEF.md
# Receiver Data Output Conditioner

This block sits between a receiver's demodulator and its DATA output pin. It turns the already synchronized demodulated bit into a clean output level that a host controller can use directly as an interrupt source. Every decision is taken on a sample-clock enable (`tick`), so the output only ever moves on tick boundaries. The time between two output edges is therefore always a whole number of tick periods.

After each output edge the level is frozen for a programmable number of ticks. A short pulse on the input that starts and ends inside that window never reaches the output. A low output level is also capped: if it lasts a programmable number of ticks, the output is forced high and a timeout flag is raised. The flag stays up until the input itself goes high again. While receive-enable is low the output idles high. The first tick after enabling only enters receiving mode; the input is followed from the next tick onward.

The controller has four named states:
- `ST_OFF`: idle, output high.
- `ST_FOLLOW`: free to copy the input.
- `ST_FREEZE`: minimum spacing not yet met.
- `ST_CAPPED`: forced high after a low timeout.

The transitions are:
- off→follow on the first enabled tick.
- follow→freeze and freeze→freeze on any output edge.
- freeze→follow on a tick where the spacing has elapsed and no edge is taken.
- follow/freeze→capped on a forced rise while the input is still low.
- capped→freeze on the first tick with the input high.
- any→off whenever receive-enable is low.

Top module: `rx_data_conditioner`

## Requirements
- R1: While `rst_n` is low or `rx_en` is low, `data_out` is 1 and `low_timeout` is 0 from the next clock edge on, regardless of `demod_in`.
- R2: On the first `tick` with `rx_en` high after a disabled period, `data_out` stays 1 even if `demod_in` is 0; the input is followed from the following tick.
- R3: With `rx_en` high, `data_out` and `low_timeout` change only on clock edges where `tick` is 1; changes of `demod_in` between ticks have no effect.
- R4: When no spacing window is active and `demod_in` differs from `data_out` on a tick, `data_out` takes the value of `demod_in` on that tick's clock edge.
- R5: After an output edge on tick k, the next normal edge may occur no earlier than tick k+`min_gap`; a `min_gap` of 0 acts as 1.
- R6: A difference between `demod_in` and `data_out` seen on ticks inside the spacing window is ignored; if the input is back at the output level when the window ends, no edge appears.
- R7: After a falling edge on tick k with the output still low, `data_out` is forced to 1 on tick k+`max_low` (a value of 0 acts as 1); if `demod_in` is 0 on that tick, `low_timeout` becomes 1. The forced rise takes priority over the spacing window.
- R8: While `low_timeout` is 1, `data_out` stays 1; the flag clears on the first tick with `demod_in` = 1. The output then follows the input again, with spacing counted from the forced rise.
- R9: If `demod_in` is 1 on the tick where the low limit is reached, the output rises as a normal edge and `low_timeout` stays 0.

`max_low` is expected to be at least `min_gap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample-clock enable, one clock wide |
| demod_in | input | 1 | Synchronized demodulator bit |
| rx_en | input | 1 | Receive enable |
| min_gap | input | CNT_W | Minimum ticks between output edges |
| max_low | input | CNT_W | Maximum ticks the output may stay low |
| data_out | output | 1 | Conditioned DATA level |
| low_timeout | output | 1 | Set when a low level was cut short |

## Verification
A shared span counter that restarts on the wrong cycle, or is off by one, shifts the earliest permitted edge or the forced rise by a tick. That error shows at `data_out` on the very next tick that tests the boundary. A controller stuck in the capped or freeze state shows as a missing edge, or as a flag still up, on the first tick where the input should have been followed. Because expectations are compared after every tick and checked for stability between ticks, any such divergence is reported within one tick period of its cause.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_FOLLOW = 2'd1,
        ST_FREEZE = 2'd2,
        ST_CAPPED = 2'd3
    } rxc_state_t;

endpackage

// File: rtl/rxc_span_counter.sv
// Counts ticks since the most recent output edge; saturates at all ones.
module rxc_span_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= ONE;
        end else if (tick && (count != TOP)) begin
            count <= count + ONE;
        end
    end
endmodule

// File: rtl/rxc_limit_cmp.sv
// Compares the span against the spacing and low-time limits.
module rxc_limit_cmp #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] min_gap,
    input  logic [CNT_W-1:0] max_low,
    output logic             gap_open,
    output logic             low_over
);
    always_comb begin
        gap_open = (count >= min_gap);
        low_over = (count >= max_low);
    end
endmodule

// File: rtl/rxc_fsm.sv
module rxc_fsm
    import rxc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_en,
    input  logic din,
    input  logic gap_open,
    input  logic low_over,
    output logic restart,
    output logic data_q,
    output logic flag_q
);
    rxc_state_t state, state_n;
    logic       data_n, flag_n, free;

    always_comb begin
        state_n = state;
        data_n  = data_q;
        flag_n  = flag_q;
        restart = 1'b0;
        free    = (state == ST_FOLLOW) || gap_open;
        if (!rx_en) begin
            state_n = ST_OFF;
            data_n  = 1'b1;
            flag_n  = 1'b0;
        end else if (tick) begin
            unique case (state)
                ST_OFF: begin
                    state_n = ST_FOLLOW;
                end
                ST_FOLLOW, ST_FREEZE: begin
                    if (!data_q && low_over) begin
                        data_n  = 1'b1;
                        restart = 1'b1;
                        if (din) begin
                            state_n = ST_FREEZE;
                        end else begin
                            state_n = ST_CAPPED;
                            flag_n  = 1'b1;
                        end
                    end else if (free && (din != data_q)) begin
                        data_n  = din;
                        restart = 1'b1;
                        state_n = ST_FREEZE;
                    end else if (free) begin
                        state_n = ST_FOLLOW;
                    end
                end
                ST_CAPPED: begin
                    if (din) begin
                        flag_n  = 1'b0;
                        state_n = ST_FREEZE;
                    end
                end
                default: state_n = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= 1'b1;
            flag_q <= 1'b0;
        end else begin
            data_q <= data_n;
            flag_q <= flag_n;
        end
    end
endmodule

// File: rtl/rx_data_conditioner.sv
module rx_data_conditioner #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             demod_in,
    input  logic             rx_en,
    input  logic [CNT_W-1:0] min_gap,
    input  logic [CNT_W-1:0] max_low,
    output logic             data_out,
    output logic             low_timeout
);
    logic [CNT_W-1:0] span;
    logic             restart, gap_open, low_over;

    rxc_span_counter #(.CNT_W(CNT_W)) u_span (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (restart),
        .count   (span)
    );

    rxc_limit_cmp #(.CNT_W(CNT_W)) u_cmp (
        .count    (span),
        .min_gap  (min_gap),
        .max_low  (max_low),
        .gap_open (gap_open),
        .low_over (low_over)
    );

    rxc_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rx_en    (rx_en),
        .din      (demod_in),
        .gap_open (gap_open),
        .low_over (low_over),
        .restart  (restart),
        .data_q   (data_out),
        .flag_q   (low_timeout)
    );
endmodule

// File: rtl/rxc_checker.sv
module rxc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             demod_in,
    input logic             rx_en,
    input logic [CNT_W-1:0] min_gap,
    input logic [CNT_W-1:0] max_low,
    input logic             data_out,
    input logic             low_timeout
);
    logic             prev_d, armed, chg;
    logic [CNT_W-1:0] span, span_eff;
    logic [CNT_W:0]   spans1, low_lim;

    assign chg      = (data_out != prev_d);
    assign span_eff = chg ? '0 : span;
    assign spans1   = {1'b0, span_eff} + (CNT_W+1)'(1);
    assign low_lim  = (max_low == '0) ? (CNT_W+1)'(1) : {1'b0, max_low};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_d <= 1'b1;
            armed  <= 1'b0;
            span   <= '0;
        end else begin
            prev_d <= data_out;
            armed  <= rx_en & (armed | chg);
            span   <= (span_eff == {CNT_W{1'b1}}) ? span_eff : span_eff + CNT_W'(tick);
        end
    end

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (data_out && !low_timeout));

    p_tick_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && rx_en) |=> ($stable(data_out) && $stable(low_timeout)));

    p_min_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && $past(tick) && $past(rx_en) && $past(armed)
         && !(data_out && ($past(spans1) >= {1'b0, max_low})))
        |-> ($past(spans1) >= {1'b0, min_gap}));

    p_low_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && tick && !data_out) |-> (spans1 <= low_lim));

    p_flag_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_timeout) |-> ($past(tick) && !$past(demod_in) && !$past(data_out)));

    p_flag_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        low_timeout |-> data_out);

    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(low_timeout) |-> (!$past(rx_en) || ($past(tick) && $past(demod_in))));
endmodule

bind rx_data_conditioner rxc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .demod_in    (demod_in),
    .rx_en       (rx_en),
    .min_gap     (min_gap),
    .max_low     (max_low),
    .data_out    (data_out),
    .low_timeout (low_timeout)
);

// File: tb/rx_data_conditioner_test.sv
module rx_data_conditioner_test;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic demod_in = 1'b1;
    logic rx_en = 1'b0;
    logic [CNT_W-1:0] min_gap = 16'd3;
    logic [CNT_W-1:0] max_low = 16'd8;
    logic data_out, low_timeout;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    bit    exp_d[$];
    bit    exp_f[$];
    string exp_tag[$];

    bit m_on = 1'b0, m_d = 1'b1, m_f = 1'b0, m_timed = 1'b0;
    int since = 0;
    bit cur_d = 1'b1, cur_f = 1'b0;

    always #4 clk = ~clk;

    rx_data_conditioner #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .demod_in(demod_in),
        .rx_en(rx_en), .min_gap(min_gap), .max_low(max_low),
        .data_out(data_out), .low_timeout(low_timeout)
    );

    task automatic check(input string tag, input bit d, input bit f);
        checks++;
        if (data_out !== d || low_timeout !== f) begin
            fails++;
            $display("FAIL %s: data_out=%b low_timeout=%b expected %b %b",
                     tag, data_out, low_timeout, d, f);
        end
    endtask

    task automatic step(input logic din, input logic en, input string tag);
        @(negedge clk);
        demod_in = din;
        rx_en    = en;
        tick     = 1'b1;
        if (!en) begin
            m_d = 1'b1; m_f = 1'b0; m_on = 1'b0; m_timed = 1'b0;
        end else if (!m_on) begin
            m_on = 1'b1;
            since = 1 << 20;
        end else begin
            since++;
            if (m_timed) begin
                if (din) begin
                    m_timed = 1'b0;
                    m_f = 1'b0;
                end
            end else if (!m_d && since >= int'(max_low)) begin
                m_d = 1'b1;
                since = 0;
                if (!din) begin
                    m_timed = 1'b1;
                    m_f = 1'b1;
                end
            end else if (din != m_d && since >= int'(min_gap)) begin
                m_d = din;
                since = 0;
            end
        end
        exp_d.push_back(m_d);
        exp_f.push_back(m_f);
        exp_tag.push_back(tag);
        @(negedge clk);
        tick = 1'b0;
        demod_in = ~din;
        @(negedge clk);
        demod_in = din;
        @(negedge clk);
    endtask

    // Monitor: compare after each tick edge, and check stability between ticks (R3)
    initial begin
        forever begin
            bit wt;
            @(posedge clk);
            wt = tick;
            @(negedge clk);
            if (rst_n) begin
                if (wt && exp_d.size() > 0) begin
                    cur_d = exp_d.pop_front();
                    cur_f = exp_f.pop_front();
                    check(exp_tag.pop_front(), cur_d, cur_f);
                end else if (rx_en) begin
                    check("R3 between ticks", cur_d, cur_f);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", 1'b1, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 1'b1, 1'b0);

        step(1'b0, 1'b0, "R1 disabled ignores low input");
        step(1'b0, 1'b1, "R2 enable tick keeps high");
        step(1'b0, 1'b1, "R4 follow falling edge");
        step(1'b1, 1'b1, "R6 frozen tick1");
        step(1'b0, 1'b1, "R6 frozen tick2");
        step(1'b0, 1'b1, "R6 spike suppressed");
        step(1'b1, 1'b1, "R4 follow rising edge");
        step(1'b0, 1'b1, "R5 gap tick1");
        step(1'b0, 1'b1, "R5 gap tick2");
        step(1'b0, 1'b1, "R5 edge at exact gap");
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, "R7 low then forced high");
        step(1'b0, 1'b1, "R8 flag holds while input low");
        step(1'b1, 1'b1, "R8 flag clears on high input");
        step(1'b0, 1'b1, "R8 follows again after cap");
        for (int i = 0; i < 7; i++) step(1'b0, 1'b1, "R7 low within limit");
        step(1'b1, 1'b1, "R9 high input at limit, no flag");
        step(1'b0, 1'b1, "R5 frozen after rise");
        step(1'b0, 1'b1, "R5 frozen after rise");
        step(1'b0, 1'b1, "R4 fall after gap");
        step(1'b0, 1'b0, "R1 disable forces high");
        step(1'b0, 1'b1, "R2 re-enable keeps high");
        step(1'b0, 1'b1, "R4 follow after re-enable");

        step(1'b1, 1'b0, "R1 disabled");
        min_gap = 16'd0;
        max_low = 16'd1;
        step(1'b1, 1'b1, "R2 enable tick");
        step(1'b0, 1'b1, "R4 fall with zero gap");
        step(1'b1, 1'b1, "R9 limit one with high input");
        step(1'b0, 1'b1, "R5 zero gap acts as one");
        step(1'b0, 1'b1, "R7 limit one forces high");
        step(1'b1, 1'b1, "R8 clear");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule